// File: doc/BRIEF.md
# Queued SPI Master Engine

This block is an SPI master that works through a list of up to sixteen transfers with no further help from the host once it has been started. Each list slot has three parts: a command byte, a transmit word and a receive word. The host fills the command and transmit memories through a write port. It selects the first and last slot of the run and the shared timing settings, then pulses `start`.

For each slot, the engine drives the slot's four-bit chip-select pattern. It waits a lead time, then shifts the low bits of the transmit word out on `mosi`, most significant bit first. It clocks in `miso` on each rising edge of `sck`, and stores the received bits right-justified in the receive slot with the same index. After a trailing gap it moves to the next slot. A command bit can keep the chip selects asserted between slots, so a peripheral sees one long transfer. When the last slot is finished, the engine releases the chip selects and raises a sticky `done`.

The command byte is decoded as follows. Bit 7 keeps the chip selects asserted. Bit 6 selects the programmable length. Bit 5 selects the programmable trailing gap. Bit 4 selects the programmable lead time. Bits 3..0 are the chip-select pattern.

Neither the write port nor the read port has back-pressure. Every write strobe is accepted in the cycle it is given, and the receive read data is combinational from `rx_rd_addr`.

Top module: `spiq_master`

## Requirements
- R1: After reset, `sck`, `pcs`, `busy` and `done` are all 0.
- R2: After `start` in idle, the engine runs one transfer for each slot from `queue_first` to `queue_last` inclusive, in rising index order. During every `sck` pulse of a slot, `pcs` equals bits 3..0 of that slot's command.
- R3: The transfer length follows two rules. When command bit 6 is 0, the length is 8 bits. When bit 6 is 1, the length comes from `bits_sel`: 0 gives 16 bits, 1 to 7 give 8 bits, and 8 to 15 give that number of bits.
- R4: For an N-bit transfer, `mosi` carries bits N-1 down to 0 of the slot's transmit word, most significant first. `mosi` changes only while `sck` is low.
- R5: `miso` is sampled on each rising `sck` edge. The N received bits are stored right-justified in the receive slot with the same index, with the upper bits zero, and can be read through `rx_rd_addr`/`rx_rd_data`.
- R6: On the falling `sck` edge that ends a slot, `pcs` stays at the slot's pattern when command bit 7 is 1 and returns to 0 when it is 0.
- R7: The lead time runs from the clock where `pcs` takes the first slot's pattern to the first rising `sck` edge. It is `lead_dly` clocks when command bit 4 is 1, where 0 counts as 1, and one `sck` half period when bit 4 is 0.
- R8: After the final falling `sck` edge of a slot, the engine waits `gap_dly` clocks when command bit 5 is 1, where 0 counts as 1, and 17 clocks when bit 5 is 0. For the last slot, `done` rises when this gap ends.
- R9: `sck` idles low, and each high and low phase lasts `sck_half` clocks, where 0 counts as 1.
- R10: `done` is sticky until the next accepted `start`. When `done` is set, `busy` is 0 and `pcs` is 0. A `start` pulse while busy has no effect.
- R11: The engine never changes the command or transmit memories, so running the same list again produces the same `mosi` words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_en | input | 1 | Host write strobe |
| host_wr_tx | input | 1 | 1 writes the transmit memory, 0 writes the command memory (low 8 data bits) |
| host_wr_addr | input | 4 | Slot written |
| host_wr_data | input | 16 | Write data |
| rx_rd_addr | input | 4 | Receive slot read |
| rx_rd_data | output | 16 | Receive slot contents |
| queue_first | input | 4 | First slot of a run |
| queue_last | input | 4 | Last slot of a run |
| bits_sel | input | 4 | Shared transfer-length field |
| sck_half | input | 8 | Clocks per `sck` phase |
| lead_dly | input | 8 | Programmable lead time in clocks |
| gap_dly | input | 8 | Programmable trailing gap in clocks |
| start | input | 1 | Start pulse |
| busy | output | 1 | Run in progress |
| done | output | 1 | Sticky run-complete flag |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| pcs | output | 4 | Chip-select pattern, 0 when idle |

## Verification
The bench targets the length mapping at its edges: `bits_sel` values of 0, 3, 8, 12 and 15. A wrong mapping would shift the wrong number of bits, which splits slots in the wrong place and corrupts both the transmit and receive words. It measures the lead time and trailing gap with the programmable value at 0 and at larger values, against the half-period and 17-clock defaults, so an off-by-one counter shows up as a measured clock count that is wrong. It checks chip-select retention on the falling edge of each slot, a single-slot list, a `start` pulse during a run and an `sck_half` of 0. It also reruns an unchanged list to catch any engine write into the host memories.

// File: rtl/spiq_pkg.sv
package spiq_pkg;
  localparam int SPIQ_CS = 4;

  typedef struct packed {
    logic               hold_cs;
    logic               use_bits;
    logic               use_gap;
    logic               use_lead;
    logic [SPIQ_CS-1:0] cs_pat;
  } spiq_cmd_t;

  localparam int SPIQ_CMD_W = $bits(spiq_cmd_t);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_LEAD,
    ST_SHIFT,
    ST_POST
  } spiq_state_t;
endpackage

// File: rtl/spiq_ram.sv
module spiq_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/spiq_shifter.sv
module spiq_shifter #(
  parameter int DATA_W = 16,
  parameter int NB_W   = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NB_W-1:0]   nbits,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              shift_out,
  input  logic              shift_in,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
      rx_sr <= '0;
    end else if (load) begin
      // left-align the right-justified word so the top bit leaves first
      tx_sr <= tx_word << (DATA_W - int'(nbits));
      rx_sr <= '0;
    end else begin
      if (shift_out) tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
      if (shift_in)  rx_sr <= {rx_sr[DATA_W-2:0], miso};
    end
  end

  assign mosi    = tx_sr[DATA_W-1];
  assign rx_word = rx_sr;
endmodule

// File: rtl/spiq_master.sv
module spiq_master
  import spiq_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int DATA_W    = 16,
  parameter int DIV_W     = 8,
  parameter int DLY_W     = 8,
  parameter int GAP_FIXED = 17,
  parameter int AW        = $clog2(DEPTH),
  parameter int FIELD_W   = $clog2(DATA_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr_en,
  input  logic               host_wr_tx,
  input  logic [AW-1:0]      host_wr_addr,
  input  logic [DATA_W-1:0]  host_wr_data,
  input  logic [AW-1:0]      rx_rd_addr,
  output logic [DATA_W-1:0]  rx_rd_data,
  input  logic [AW-1:0]      queue_first,
  input  logic [AW-1:0]      queue_last,
  input  logic [FIELD_W-1:0] bits_sel,
  input  logic [DIV_W-1:0]   sck_half,
  input  logic [DLY_W-1:0]   lead_dly,
  input  logic [DLY_W-1:0]   gap_dly,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic               sck,
  output logic               mosi,
  input  logic               miso,
  output logic [SPIQ_CS-1:0] pcs
);
  localparam int NB_W = $clog2(DATA_W + 1);
  localparam int TW   = (DLY_W > DIV_W) ? DLY_W : DIV_W;

  spiq_state_t         state;
  logic [AW-1:0]       ptr;
  logic [TW-1:0]       cnt;
  logic [NB_W-1:0]     bits_left;
  spiq_cmd_t           cur;
  logic [SPIQ_CMD_W-1:0] cmd_raw;
  logic [DATA_W-1:0]   tx_word;
  logic [DATA_W-1:0]   rx_word;
  spiq_cmd_t           cmd_rd;
  logic [NB_W-1:0]     len_rd;
  logic [TW-1:0]       half;
  logic                tick, last_fall;
  logic                do_load, do_in, do_out, rx_we;

  function automatic logic [NB_W-1:0] xfer_len(input logic sel,
                                               input logic [FIELD_W-1:0] f);
    if (!sel)                          return NB_W'(8);
    if (f == '0)                       return NB_W'(DATA_W);
    if (int'(f) < 8)                   return NB_W'(8);
    return NB_W'(f);
  endfunction

  function automatic logic [TW-1:0] at_least_one(input logic [TW-1:0] v);
    return (v == '0) ? TW'(1) : v;
  endfunction

  spiq_ram #(.W(SPIQ_CMD_W), .DEPTH(DEPTH), .AW(AW)) u_cmd_ram (
    .clk(clk), .we(host_wr_en && !host_wr_tx), .waddr(host_wr_addr),
    .wdata(host_wr_data[SPIQ_CMD_W-1:0]), .raddr(ptr), .rdata(cmd_raw));

  spiq_ram #(.W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_tx_ram (
    .clk(clk), .we(host_wr_en && host_wr_tx), .waddr(host_wr_addr),
    .wdata(host_wr_data), .raddr(ptr), .rdata(tx_word));

  spiq_ram #(.W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_rx_ram (
    .clk(clk), .we(rx_we), .waddr(ptr), .wdata(rx_word),
    .raddr(rx_rd_addr), .rdata(rx_rd_data));

  assign cmd_rd    = spiq_cmd_t'(cmd_raw);
  assign len_rd    = xfer_len(cmd_rd.use_bits, bits_sel);
  assign half      = at_least_one(TW'(sck_half));
  assign tick      = (cnt == TW'(1));
  assign last_fall = (state == ST_SHIFT) && tick && sck && (bits_left == NB_W'(1));
  assign do_load   = (state == ST_LOAD);
  assign do_in     = tick && !sck && ((state == ST_LEAD) || (state == ST_SHIFT));
  assign do_out    = (state == ST_SHIFT) && tick && sck && !last_fall;
  assign rx_we     = last_fall;

  spiq_shifter #(.DATA_W(DATA_W), .NB_W(NB_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(do_load), .nbits(len_rd),
    .tx_word(tx_word), .shift_out(do_out), .shift_in(do_in),
    .miso(miso), .mosi(mosi), .rx_word(rx_word));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ptr       <= '0;
      cnt       <= '0;
      bits_left <= '0;
      cur       <= '0;
      sck       <= 1'b0;
      pcs       <= '0;
      done      <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          ptr   <= queue_first;
          done  <= 1'b0;
          state <= ST_LOAD;
        end
        ST_LOAD: begin
          cur       <= cmd_rd;
          pcs       <= cmd_rd.cs_pat;
          bits_left <= len_rd;
          cnt       <= cmd_rd.use_lead ? at_least_one(TW'(lead_dly)) : half;
          state     <= ST_LEAD;
        end
        ST_LEAD: if (tick) begin
          sck   <= 1'b1;
          cnt   <= half;
          state <= ST_SHIFT;
        end else cnt <= cnt - TW'(1);
        ST_SHIFT: if (tick) begin
          sck <= !sck;
          cnt <= half;
          if (last_fall) begin
            cnt   <= cur.use_gap ? at_least_one(TW'(gap_dly)) : TW'(GAP_FIXED);
            state <= ST_POST;
            if (!cur.hold_cs) pcs <= '0;
          end else if (sck) begin
            bits_left <= bits_left - NB_W'(1);
          end
        end else cnt <= cnt - TW'(1);
        ST_POST: if (tick) begin
          if (ptr == queue_last) begin
            done  <= 1'b1;
            pcs   <= '0;
            state <= ST_IDLE;
          end else begin
            ptr   <= ptr + AW'(1);
            state <= ST_LOAD;
          end
        end else cnt <= cnt - TW'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/spiq_master_chk.sv
module spiq_master_chk #(
  parameter int CS_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            sck,
  input logic            mosi,
  input logic [CS_W-1:0] pcs
);
  AST_SCK_LOW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_PCS_RELEASED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pcs == '0)); // R10
  AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done)); // R10
  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy)); // R8
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> $stable(mosi)); // R4
endmodule

bind spiq_master spiq_master_chk #(.CS_W(spiq_pkg::SPIQ_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .sck(sck), .mosi(mosi), .pcs(pcs));

// File: tb/spiq_master_test.sv
module spiq_master_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        host_wr_en = 0, host_wr_tx = 0;
  logic [3:0]  host_wr_addr = 0;
  logic [15:0] host_wr_data = 0;
  logic [3:0]  rx_rd_addr = 0;
  logic [15:0] rx_rd_data;
  logic [3:0]  queue_first = 0, queue_last = 0, bits_sel = 0;
  logic [7:0]  sck_half = 1, lead_dly = 0, gap_dly = 0;
  logic        start = 0;
  logic        busy, done, sck, mosi, miso;
  logic [3:0]  pcs;

  spiq_master uut (.*);

  int errors = 0, checks = 0;
  logic [7:0]  m_cmd [16];
  logic [15:0] m_tx [16];
  logic [15:0] m_miso [16];
  int e_addr [16];
  int e_n [16];
  int L = 0;
  bit mon_on = 0;
  int mj, mk, rises, lead_cnt, post_cnt, hi_cnt, hi_min, hi_max;
  logic [15:0] got_tx [16];
  logic [15:0] keep_tx [16];
  logic [3:0]  after_pcs [16];
  int bad_pcs [16];
  bit prev_sck;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int blen(input logic [7:0] c);
    if (!c[6]) return 8;
    if (bits_sel == 0) return 16;
    if (bits_sel < 8) return 8;
    return int'(bits_sel);
  endfunction

  function automatic int hval();
    return (sck_half == 0) ? 1 : int'(sck_half);
  endfunction

  assign miso = (mon_on && mj < L && mk < e_n[mj]) ? m_miso[e_addr[mj]][e_n[mj]-1-mk] : 1'b0;

  always @(negedge clk) if (mon_on) begin
    if (sck && !prev_sck) begin
      rises++;
      hi_cnt = 0;
      if (mj < L) begin
        got_tx[mj] = {got_tx[mj][14:0], mosi};
        if (pcs !== m_cmd[e_addr[mj]][3:0]) bad_pcs[mj]++;
        mk++;
      end
    end
    if (sck) hi_cnt++;
    if (!sck && prev_sck) begin
      if (hi_cnt < hi_min) hi_min = hi_cnt;
      if (hi_cnt > hi_max) hi_max = hi_cnt;
      if (mj < L && mk == e_n[mj]) begin
        after_pcs[mj] = pcs;
        mj++;
        mk = 0;
        if (mj == L) post_cnt = 1;
      end
    end else if (mj == L && !done && post_cnt > 0) post_cnt++;
    if (mj == 0 && mk == 0 && !sck && pcs != 0) lead_cnt++;
    prev_sck = sck;
  end

  task automatic wr(input bit tx, input int a, input logic [15:0] d);
    @(negedge clk);
    host_wr_en = 1; host_wr_tx = tx; host_wr_addr = 4'(a); host_wr_data = d;
    @(negedge clk);
    host_wr_en = 0;
    if (tx) m_tx[a] = d; else m_cmd[a] = d[7:0];
  endtask

  task automatic run(input int qs, input int qe, input bit poke, input bit keep, input bit cmp);
    int tot, wait_n, mask, first_c, last_c, exp_lead, exp_post;
    L = qe - qs + 1;
    tot = 0;
    for (int j = 0; j < L; j++) begin
      e_addr[j] = qs + j; e_n[j] = blen(m_cmd[qs+j]); tot += e_n[j];
      got_tx[j] = 0; bad_pcs[j] = 0; after_pcs[j] = 4'hx;
    end
    queue_first = 4'(qs); queue_last = 4'(qe);
    mj = 0; mk = 0; rises = 0; lead_cnt = 0; post_cnt = 0; hi_cnt = 0;
    hi_min = 1000; hi_max = 0; prev_sck = 0; mon_on = 1;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1; @(negedge clk) start = 0;
    end
    wait_n = 0;
    while (!done && wait_n < 20000) begin @(negedge clk); wait_n++; end
    chk(done, "R10 done after run", done, 1);
    repeat (3) @(negedge clk);
    mon_on = 0;
    chk(done && !busy && pcs == 0, "R10 idle after done", {done, busy, pcs}, 32);
    chk(mj == L, "R2 slots run", mj, L);
    chk(rises == tot, "R3 total bits", rises, tot);
    first_c = m_cmd[qs]; last_c = m_cmd[qe];
    exp_lead = first_c[4] ? ((lead_dly == 0) ? 1 : int'(lead_dly)) : hval();
    exp_post = last_c[5] ? ((gap_dly == 0) ? 1 : int'(gap_dly)) : 17;
    chk(lead_cnt == exp_lead, "R7 lead clocks", lead_cnt, exp_lead);
    chk(post_cnt == exp_post, "R8 gap clocks", post_cnt, exp_post);
    chk(hi_min == hval() && hi_max == hval(), "R9 sck phase", hi_max, hval());
    for (int j = 0; j < L; j++) begin
      mask = (1 << e_n[j]) - 1;
      chk(int'(got_tx[j]) == (int'(m_tx[e_addr[j]]) & mask), "R4 mosi word",
          got_tx[j], int'(m_tx[e_addr[j]]) & mask);
      chk(bad_pcs[j] == 0, "R2 pcs during pulses", bad_pcs[j], 0);
      chk(after_pcs[j] === (m_cmd[e_addr[j]][7] ? m_cmd[e_addr[j]][3:0] : 4'h0),
          "R6 pcs after slot", after_pcs[j], m_cmd[e_addr[j]][7] ? m_cmd[e_addr[j]][3:0] : 0);
      rx_rd_addr = 4'(e_addr[j]);
      #1;
      chk(int'(rx_rd_data) == (int'(m_miso[e_addr[j]]) & mask), "R5 rx slot",
          rx_rd_data, int'(m_miso[e_addr[j]]) & mask);
      if (keep) keep_tx[j] = got_tx[j];
      if (cmp) chk(got_tx[j] == keep_tx[j], "R11 rerun word", got_tx[j], keep_tx[j]);
    end
  endtask

  initial begin
    #1_900_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 16; i++) begin m_cmd[i] = 0; m_tx[i] = 0; m_miso[i] = 0; end
    repeat (3) @(negedge clk);
    chk(!sck && pcs == 0 && !busy && !done, "R1 reset state", {sck, pcs, busy, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!sck && pcs == 0 && !busy && !done, "R1 after release", {sck, pcs, busy, done}, 0);
    for (int i = 0; i < 16; i++) begin wr(0, i, 16'h0001); wr(1, i, 16'h0); end

    // single 8-bit slot, default lead and gap (R2 R3 R4)
    wr(0, 0, 16'h0001); wr(1, 0, 16'hA5C3); m_miso[0] = 16'h005A;
    sck_half = 2;
    run(0, 0, 0, 0, 0);

    // length field corners with a held chip select (R3 R6)
    wr(0, 4, 16'h00C2); wr(0, 5, 16'h0058);
    wr(1, 4, 16'hF0E1); wr(1, 5, 16'h1234);
    m_miso[4] = 16'hBEEF; m_miso[5] = 16'h7E81;
    lead_dly = 5;
    foreach (e_n[k]) if (k < 5) begin
      case (k) 0: bits_sel = 0; 1: bits_sel = 3; 2: bits_sel = 8; 3: bits_sel = 12; default: bits_sel = 15; endcase
      run(4, 5, 0, 0, 0);
    end

    // programmable lead and gap at 0 and 3, sck_half 0 (R7 R8 R9)
    wr(0, 7, 16'h00B3); wr(1, 7, 16'h00FF); m_miso[7] = 16'h0081;
    sck_half = 0; lead_dly = 0; gap_dly = 0;
    run(7, 7, 0, 0, 0);
    lead_dly = 3; gap_dly = 3; sck_half = 3;
    run(7, 7, 0, 0, 0);

    // start pulse during run is ignored, then rerun unchanged (R10 R11)
    run(4, 7, 1, 1, 0);
    run(4, 7, 0, 0, 1);

    // random lists
    for (int it = 0; it < 20; it++) begin
      int a, b;
      for (int i = 0; i < 16; i++) begin
        logic [7:0] c;
        c = 8'($urandom());
        if (c[3:0] == 0) c[0] = 1'b1;
        wr(0, i, {8'h00, c});
        wr(1, i, 16'($urandom()));
        m_miso[i] = 16'($urandom());
      end
      a = $urandom_range(15, 0); b = $urandom_range(15, 0);
      if (a > b) begin int t; t = a; a = b; b = t; end
      bits_sel = 4'($urandom()); sck_half = 8'($urandom_range(3, 0));
      lead_dly = 8'($urandom_range(6, 0)); gap_dly = 8'($urandom_range(6, 0));
      run(a, b, 0, 0, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule